// File: doc/BRIEF.md
# Mixed-Signal Capture Record Buffer

This block keeps a fixed-length record of combined samples. Each sample is a 10-bit analog conversion result plus 8 logic-channel bits. Once armed, it writes every incoming sample into a circular store, so the newest samples are always held. A trigger pulse or a force-capture pulse closes the record. The block then keeps capturing until the record is full, and reports that data is ready.

A host steers the block with three pulses: reset, arm and force. It reads one status byte per query. When the status shows data ready, a dump request streams the record out, oldest sample first, as a byte sequence under valid/ready flow control. Each sample becomes three bytes. Only the low six bits of each byte carry data, and the analog and logic fields are split across the byte boundaries. The trigger detector and the serial transmitter sit outside this block.

Top module: `capbuf_top`

## Requirements
- R1: After reset, `outValid` is 0 and a status query returns 0x00 (idle).
- R2: A `statusReq` pulse gives `statusValid` high for one cycle on the next cycle. `statusByte` then holds the state at the request edge: 0x00 idle, 0x01 armed, 0x02 filling, 0x03 data ready, 0x04 dumping.
- R3: `ctlArm` takes effect only in idle. It moves the block to armed and clears the stored record. `ctlArm` in any other state is ignored. `ctlReset` returns the block to idle from any state and takes priority over every other input.
- R4: While armed, each `sampleEn` cycle stores {`logicIn`,`adcIn`} in a circular store of DEPTH (1024) entries, so only the newest 1024 samples are kept.
- R5: `trigIn` or `ctlForce` while armed starts filling; a sample presented with `sampleEn` in that same cycle is stored. Filling stores samples until 1024 have been stored since arming, and data ready follows one cycle later. If 1024 are already stored, data ready follows on the next cycle. `trigIn` and `ctlForce` have no effect outside the armed state.
- R6: In the data-ready state, samples are ignored and the record is unchanged.
- R7: `dumpReq` in the data-ready state starts a dump of exactly 3072 bytes, oldest sample first. After the last byte is accepted, the block returns to idle.
- R8: Sample bytes go out in this order: byte 0 = analog[5:0] in bits 5:0; byte 1 = analog[9:6] in bits 3:0 and logic[1:0] in bits 5:4; byte 2 = logic[7:2] in bits 5:0.
- R9: Bits 7:6 of every output byte are zero.
- R10: A byte is accepted in a cycle where `outValid` and `outReady` are both high. While `outValid` is high and `outReady` is low, `outValid` stays high and `outByte` does not change.
- R11: `dumpReq` outside the data-ready state is ignored: no byte is presented and the status is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample strobe |
| adcIn | input | 10 | Analog sample value |
| logicIn | input | 8 | Logic channel values |
| trigIn | input | 1 | Trigger pulse from the external detector |
| ctlReset | input | 1 | Return to idle |
| ctlArm | input | 1 | Arm capture (from idle) |
| ctlForce | input | 1 | Close the record without a trigger |
| statusReq | input | 1 | Status query pulse |
| statusValid | output | 1 | Status byte valid |
| statusByte | output | 8 | Status code |
| dumpReq | input | 1 | Request record dump |
| outValid | output | 1 | Dump byte valid |
| outReady | input | 1 | Sink accepts byte |
| outByte | output | 8 | Dump byte |

## Verification
The two kinds of internal fault show up differently at the ports.

- A wrong write pointer or fill count corrupts the record itself. The dump then shows it from the first byte: either the wrong oldest sample, or a sample repeated or missing at the wrap point. The sweeps drive every sample from an arithmetic sequence, so each of the 3072 bytes has its own expected value, and a mismatch is caught on the byte where it appears.
- A wrong control state shows up within one query. The status byte is wrong, or data ready arrives a cycle early or late against the sample count. The early-or-late check is made with a query placed exactly one cycle after the record completes.

// File: rtl/capbuf_pkg.sv
`timescale 1ns/1ps
package capbuf_pkg;
  localparam int ADC_W    = 10;
  localparam int LOGIC_W  = 8;
  localparam int SAMPLE_W = ADC_W + LOGIC_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_FILL  = 3'd2,
    ST_READY = 3'd3,
    ST_DUMP  = 3'd4
  } capState_t;

  typedef struct packed {
    logic wrEn;
    logic ptrClr;
    logic rdLoad;
    logic rdStep;
  } capStrobe_t;

  // sample word is {logic[7:0], adc[9:0]}
  function automatic logic [7:0] packByte(input logic [SAMPLE_W-1:0] s,
                                          input logic [1:0] sel);
    logic [7:0] b;
    case (sel)
      2'd0:    b = {2'b00, s[5:0]};
      2'd1:    b = {2'b00, s[11:10], s[9:6]};
      default: b = {2'b00, s[17:12]};
    endcase
    return b;
  endfunction
endpackage

// File: rtl/capbuf_ctrl.sv
`timescale 1ns/1ps
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleEn,
  input  logic       trigIn,
  input  logic       ctlReset,
  input  logic       ctlArm,
  input  logic       ctlForce,
  input  logic       dumpReq,
  input  logic       outReady,
  output capStrobe_t stb,
  output capState_t  state,
  output logic       outValid
);
  localparam int AW    = $clog2(DEPTH);
  localparam int BYTES = 3 * DEPTH;
  localparam int BW    = $clog2(BYTES);
  localparam logic [AW:0]   FULL  = (AW+1)'(DEPTH);
  localparam logic [BW-1:0] LASTB = BW'(BYTES - 1);

  capState_t     nxt;
  logic [AW:0]   fillCnt;
  logic [BW-1:0] byteCnt;
  logic          accept;

  assign outValid = (state == ST_DUMP);
  assign accept   = outValid && outReady;

  always_comb begin
    nxt = state;
    stb = '0;
    stb.rdStep = accept;
    stb.wrEn = !ctlReset && sampleEn &&
               ((state == ST_ARMED) || (state == ST_FILL && fillCnt != FULL));
    case (state)
      ST_IDLE:  if (ctlArm) begin
                  nxt = ST_ARMED;
                  stb.ptrClr = !ctlReset;
                end
      ST_ARMED: if (trigIn || ctlForce) nxt = ST_FILL;
      ST_FILL:  if (fillCnt == FULL) nxt = ST_READY;
      ST_READY: if (dumpReq) begin
                  nxt = ST_DUMP;
                  stb.rdLoad = !ctlReset;
                end
      ST_DUMP:  if (accept && byteCnt == LASTB) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (ctlReset) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
      byteCnt <= '0;
    end else begin
      state <= nxt;
      if (stb.ptrClr)                          fillCnt <= '0;
      else if (stb.wrEn && fillCnt != FULL)    fillCnt <= fillCnt + 1'b1;
      if (stb.rdLoad)      byteCnt <= '0;
      else if (accept)     byteCnt <= byteCnt + 1'b1;
    end
  end
endmodule

// File: rtl/capbuf_data.sv
`timescale 1ns/1ps
module capbuf_data
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  capStrobe_t         stb,
  input  logic [ADC_W-1:0]   adcIn,
  input  logic [LOGIC_W-1:0] logicIn,
  output logic [7:0]         outByte
);
  localparam int AW = $clog2(DEPTH);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wrPtr;
  logic [AW-1:0]       rdPtr;
  logic [1:0]          byteSel;

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr] <= {logicIn, adcIn};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      byteSel <= '0;
    end else begin
      if (stb.ptrClr)    wrPtr <= '0;
      else if (stb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (stb.rdLoad) begin
        rdPtr   <= wrPtr;
        byteSel <= '0;
      end else if (stb.rdStep) begin
        if (byteSel == 2'd2) begin
          byteSel <= '0;
          rdPtr   <= rdPtr + 1'b1;
        end else begin
          byteSel <= byteSel + 1'b1;
        end
      end
    end
  end

  assign outByte = packByte(mem[rdPtr], byteSel);
endmodule

// File: rtl/capbuf_top.sv
`timescale 1ns/1ps
module capbuf_top
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleEn,
  input  logic [9:0] adcIn,
  input  logic [7:0] logicIn,
  input  logic       trigIn,
  input  logic       ctlReset,
  input  logic       ctlArm,
  input  logic       ctlForce,
  input  logic       statusReq,
  output logic       statusValid,
  output logic [7:0] statusByte,
  input  logic       dumpReq,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outByte
);
  capStrobe_t stb;
  capState_t  state;

  capbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .trigIn(trigIn),
    .ctlReset(ctlReset), .ctlArm(ctlArm), .ctlForce(ctlForce),
    .dumpReq(dumpReq), .outReady(outReady), .stb(stb), .state(state),
    .outValid(outValid)
  );

  capbuf_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .adcIn(adcIn),
    .logicIn(logicIn), .outByte(outByte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusValid <= 1'b0;
      statusByte  <= 8'h00;
    end else begin
      statusValid <= statusReq;
      if (statusReq) statusByte <= {5'd0, state};
    end
  end
endmodule

// File: rtl/capbuf_chk.sv
`timescale 1ns/1ps
module capbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctlReset,
  input logic       statusReq,
  input logic       statusValid,
  input logic [7:0] statusByte,
  input logic       dumpReq,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outByte
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady && !ctlReset) |=> (outValid && $stable(outByte)));

  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outByte[7:6] == 2'b00));

  // R2
  status_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusReq |=> (statusValid && statusByte <= 8'd4));

  // R2
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !statusReq |=> !statusValid);

  // R7
  dump_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> $past(dumpReq));

  // R3
  reset_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctlReset |=> !outValid);
endmodule

bind capbuf_top capbuf_chk u_chk (.*);

// File: tb/capbuf_top_tb.sv
`timescale 1ns/1ps
module capbuf_top_tb;
  localparam int DEPTH = 1024;
  localparam int BYTES = 3 * DEPTH;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sampleEn = 0, trigIn = 0, ctlReset = 0, ctlArm = 0, ctlForce = 0;
  logic [9:0] adcIn = '0;
  logic [7:0] logicIn = '0;
  logic       statusReq = 0, dumpReq = 0, outReady = 0;
  logic       statusValid, outValid;
  logic [7:0] statusByte, outByte;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  capbuf_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .adcIn(adcIn),
    .logicIn(logicIn), .trigIn(trigIn), .ctlReset(ctlReset), .ctlArm(ctlArm),
    .ctlForce(ctlForce), .statusReq(statusReq), .statusValid(statusValid),
    .statusByte(statusByte), .dumpReq(dumpReq), .outValid(outValid),
    .outReady(outReady), .outByte(outByte)
  );

  function automatic logic [9:0] sAdc(int k);
    return 10'((k * 173 + 11) & 1023);
  endfunction
  function automatic logic [7:0] sLg(int k);
    return 8'(((k * 29) ^ (k >> 2)) & 255);
  endfunction
  function automatic logic [7:0] expByte(int k, int b);
    logic [9:0] a;
    logic [7:0] g;
    a = sAdc(k);
    g = sLg(k);
    if (b == 0)      return {2'b00, a[5:0]};
    else if (b == 1) return {2'b00, g[1:0], a[9:6]};
    else             return {2'b00, g[7:2]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic queryStatus(input logic [7:0] exp, input string req);
    @(negedge clk); statusReq = 1'b1;
    @(negedge clk); statusReq = 1'b0;
    check(statusValid === 1'b1 && statusByte === exp, req, {statusValid, statusByte}, {1'b1, exp});
  endtask

  task automatic armSeq();
    pulse(ctlReset);
    pulse(ctlArm);
  endtask

  task automatic pushSamples(input int first, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleEn = 1'b1; adcIn = sAdc(first + i); logicIn = sLg(first + i);
    end
    @(negedge clk); sampleEn = 1'b0;
  endtask

  task automatic ignoredDump(input logic [7:0] stat, input string req);
    bit seen;
    seen = 0;
    pulse(dumpReq);
    for (int i = 0; i < 4; i++) begin
      if (outValid) seen = 1;
      @(negedge clk);
    end
    check(!seen, req, seen, 0);
    queryStatus(stat, req);
  endtask

  task automatic dumpCheck(input int first, input bit stall);
    int idx, guard, bad, pad;
    bit held;
    logic [7:0] prev;
    idx = 0; guard = 0; bad = 0; pad = 0; held = 0; prev = '0;
    @(negedge clk); dumpReq = 1'b1;
    @(negedge clk); dumpReq = 1'b0; statusReq = 1'b1;
    while (idx < BYTES && guard < 4 * BYTES) begin
      outReady = stall ? ((guard % 3) != 1) : 1'b1;
      if (guard == 1) begin
        statusReq = 1'b0;
        // R2 dumping code 0x04
        check(statusValid && statusByte == 8'h04, "R2 dumping status", statusByte, 8'h04);
      end
      if (held) check(outValid && outByte == prev, "R10 held byte", outByte, prev);
      held = 0;
      if (outValid) begin
        if (outByte[7:6] != 2'b00) pad++;
        if (outReady) begin
          if (outByte != expByte(first + idx / 3, idx % 3)) begin
            bad++;
            if (bad < 4) check(0, "R8 dump byte", outByte, expByte(first + idx / 3, idx % 3));
          end
          idx++;
        end else begin
          held = 1; prev = outByte;
        end
      end
      guard++;
      @(negedge clk);
    end
    statusReq = 1'b0;
    outReady = 1'b0;
    // R7 all bytes delivered, R4 oldest first
    check(idx == BYTES && bad == 0, "R7 R4 byte count and order", idx, BYTES);
    check(pad == 0, "R9 pad bits", pad, 0);
    check(!outValid, "R7 stream ends", outValid, 0);
  endtask

  initial begin
    #(8ns * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid, "R1 reset outValid", outValid, 0);
    rst_n = 1'b1;
    queryStatus(8'h00, "R1 idle after reset");

    // R5 trigger/force ignored outside armed
    pulse(ctlForce);
    pulse(trigIn);
    queryStatus(8'h00, "R5 force in idle ignored");
    // R11
    ignoredDump(8'h00, "R11 dump in idle");

    // Scenario A: partial prefill then forced capture
    armSeq();
    queryStatus(8'h01, "R3 armed");
    pushSamples(0, 100);
    pulse(ctlArm);
    queryStatus(8'h01, "R3 arm while armed ignored");
    ignoredDump(8'h01, "R11 dump while armed");
    pulse(ctlForce);
    queryStatus(8'h02, "R5 filling after force");
    pushSamples(100, 1100);
    @(negedge clk);
    queryStatus(8'h03, "R5 data ready");
    dumpCheck(0, 1'b0);
    queryStatus(8'h00, "R7 idle after dump");
    ignoredDump(8'h00, "R11 dump after dump");

    // Scenario B: wrapped buffer, trigger with sample, immediate ready
    armSeq();
    pushSamples(5000, 1500);
    @(negedge clk);
    trigIn = 1'b1; sampleEn = 1'b1; adcIn = sAdc(6500); logicIn = sLg(6500);
    @(negedge clk);
    trigIn = 1'b0; sampleEn = 1'b0;
    queryStatus(8'h03, "R5 full at trigger gives ready next cycle");
    pushSamples(9000, 50);
    pulse(ctlArm);
    queryStatus(8'h03, "R3 arm while ready ignored");
    // R4 wrap, R5 trigger sample kept, R6 later samples ignored, R10 stalls
    dumpCheck(5000 + 477, 1'b1);

    // Scenario C: reset from data ready
    armSeq();
    pushSamples(200, 10);
    pulse(ctlForce);
    pushSamples(210, 1100);
    @(negedge clk);
    queryStatus(8'h03, "R5 ready before reset");
    pulse(ctlReset);
    queryStatus(8'h00, "R3 reset from ready");
    ignoredDump(8'h00, "R11 dump after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule